// File: doc/BRIEF.md
# Gated pulse-train result decoder

This block rebuilds a conversion result from a single serial line. A converter forms the line by gating its own conversion clock with its busy signal, so each measurement cycle appears as one burst of pulses. The burst begins with a fixed preamble of integrate-phase pulses and continues with one pulse per deintegrate count. The decoder samples the line with a faster local clock through a synchroniser and counts rising edges. It treats a quiet gap of a programmable number of local cycles as the end of a burst. It then removes the preamble from the count and presents the result with a one-cycle valid strobe.

An over-range measurement keeps busy high for the whole cycle, so its burst has the maximum length. The decoder raises an over-range flag for any burst whose length reaches a configurable threshold. A burst no longer than the preamble decodes to zero. Pulse generation and display of the result are handled elsewhere.

Top module: `pulse_burst_decoder`

## Requirements
- R1: While reset is applied and just after it is released, `result_valid` is 0, `result` is 0 and `over_range` is 0.
- R2: Each rising edge of the synchronised `pulse_in` counts once, however long the line stays high. For a burst of N counted edges with N greater than PREAMBLE, `result` equals N minus PREAMBLE.
- R3: A burst of N counted edges with N less than or equal to PREAMBLE yields `result` equal to 0.
- R4: With each valid strobe, `over_range` is 1 exactly when the burst count is greater than or equal to OVR_COUNT, and 0 otherwise.
- R5: A burst ends once `idle_limit` consecutive local cycles pass with no counted edge. An `idle_limit` of 0 behaves as 1. Edges that are spaced by at most `idle_limit` local cycles stay in one burst.
- R6: `result_valid` is high for exactly one cycle per burst. It rises at the local clock edge that comes `idle_limit`+2 edges after the edge that first samples the burst's final rising edge into the synchroniser.
- R7: `result` and `over_range` change only together with a valid strobe, and they hold their values until the next one.
- R8: A line that stays idle produces no valid strobe.
- R9: The edge count saturates at 2^CNT_W-1 instead of wrapping. A burst longer than that decodes as the saturated count minus PREAMBLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, faster than the pulse rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | 1 | Gated pulse line, asynchronous to clk |
| idle_limit | input | GAP_W | Number of quiet local cycles that closes a burst (0 acts as 1) |
| result | output | CNT_W | Decoded value, burst count minus preamble, clamped at 0 |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| over_range | output | 1 | Set when the last burst reached the over-range length |

## Verification
The bench aims at the preamble boundary, where counts of exactly PREAMBLE and PREAMBLE+1 must give 0 and 1. A design with an off-by-one in the subtraction, or one that wraps below zero, returns a huge or shifted value there. It steps the count across OVR_COUNT, drives a burst long enough to saturate the counter, and sends pulse gaps one cycle below and at the split point of the idle limit. A wrapping counter would then report a small value without the flag, and a wrong gap comparison would merge or split bursts and change the number of strobes. It also measures the strobe's exact cycle after the last edge, including the zero-limit case, and checks that results hold steady between strobes.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  // Burst tracking state of the gap timer.
  typedef enum logic {
    GAP_IDLE   = 1'b0,
    GAP_ACTIVE = 1'b1
  } gap_state_e;

endpackage

// File: rtl/pbd_sync.sv
// Multi-flop synchroniser followed by a rising-edge detector.
module pbd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    chain_d[0] = async_i;
    prev_d     = chain_q[STAGES-1];
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_comb chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pbd_gap_timer.sv
// Tracks whether a burst is open and flags its end after a quiet gap.
module pbd_gap_timer
  import pbd_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [GAP_W-1:0] limit_i,
  output logic             end_o
);

  gap_state_e       state_q, state_d;
  logic [GAP_W-1:0] idle_q, idle_d;
  logic [GAP_W-1:0] limit_eff;
  logic             last_quiet;

  always_comb begin
    limit_eff  = (limit_i == '0) ? GAP_W'(1) : limit_i;
    last_quiet = (idle_q == limit_eff - GAP_W'(1));
    end_o      = (state_q == GAP_ACTIVE) && !edge_i && last_quiet;
  end

  always_comb begin
    state_d = state_q;
    idle_d  = idle_q;
    if (edge_i) begin
      state_d = GAP_ACTIVE;
      idle_d  = '0;
    end else if (state_q == GAP_ACTIVE) begin
      if (last_quiet) begin
        state_d = GAP_IDLE;
        idle_d  = '0;
      end else begin
        idle_d  = idle_q + GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GAP_IDLE;
      idle_q  <= '0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
    end
  end

endmodule

// File: rtl/pbd_pulse_counter.sv
// Saturating edge counter, cleared when a burst closes.
module pbd_pulse_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, count_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = edge_i && (count_q != CNT_MAX);
    count_d = count_q;
    if (clear_i) begin
      count_d = '0;
    end else if (cnt_en) begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/pbd_result.sv
// Removes the preamble, classifies over-range and registers the outputs.
module pbd_result #(
  parameter int CNT_W     = 16,
  parameter int PREAMBLE  = 10001,
  parameter int OVR_COUNT = 30002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             ovr_o
);

  localparam logic [CNT_W-1:0] PRE_V = CNT_W'(PREAMBLE);
  localparam logic [CNT_W-1:0] OVR_V = CNT_W'(OVR_COUNT);

  logic [CNT_W-1:0] result_q, result_d;
  logic             valid_q, valid_d;
  logic             ovr_q, ovr_d;
  logic [CNT_W-1:0] net_value;

  always_comb begin
    net_value = (count_i > PRE_V) ? (count_i - PRE_V) : '0;
    valid_d   = capture_i;
    result_d  = result_q;
    ovr_d     = ovr_q;
    if (capture_i) begin
      result_d = net_value;
      ovr_d    = (count_i >= OVR_V);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_d;
      ovr_q    <= ovr_d;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
  assign ovr_o    = ovr_q;

endmodule

// File: rtl/pulse_burst_decoder.sv
module pulse_burst_decoder #(
  parameter int CNT_W       = 16,
  parameter int GAP_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PREAMBLE    = 10001,
  parameter int OVR_COUNT   = 30002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [GAP_W-1:0] idle_limit,
  output logic [CNT_W-1:0] result,
  output logic             result_valid,
  output logic             over_range
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             edge_seen;
  logic             burst_end;
  logic [CNT_W-1:0] burst_count;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  pbd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pulse_in),
    .rise_o  (edge_seen)
  );

  pbd_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .edge_i  (edge_seen),
    .limit_i (idle_limit),
    .end_o   (burst_end)
  );

  pbd_pulse_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .edge_i  (edge_seen),
    .clear_i (burst_end),
    .count_o (burst_count)
  );

  pbd_result #(
    .CNT_W     (CNT_W),
    .PREAMBLE  (PREAMBLE),
    .OVR_COUNT (OVR_COUNT)
  ) u_result (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .capture_i (burst_end),
    .count_i   (burst_count),
    .result_o  (result),
    .valid_o   (result_valid),
    .ovr_o     (over_range)
  );

endmodule

// File: rtl/pbd_checker.sv
module pbd_checker #(
  parameter int CNT_W     = 16,
  parameter int PREAMBLE  = 10001,
  parameter int OVR_COUNT = 30002
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic [CNT_W-1:0] result,
  input logic             over_range,
  input logic             burst_end,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] PRE_V   = CNT_W'(PREAMBLE);
  localparam logic [CNT_W-1:0] OVR_V   = CNT_W'(OVR_COUNT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R6: the strobe never lasts two cycles
  a_r6_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R8: every strobe follows a closed burst
  a_r8_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(burst_end));

  // R7: outputs hold between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(result) && $stable(over_range)));

  // R4: flag follows the count at burst end
  a_r4_flag: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (over_range == ($past(count) >= OVR_V)));

  // R3: short bursts decode to zero
  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && (count <= PRE_V)) |=> (result == '0));

  // R9: the count sticks at its ceiling
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == CNT_MAX) && !burst_end) |=> (count == CNT_MAX));

endmodule

bind pulse_burst_decoder pbd_checker #(
  .CNT_W     (CNT_W),
  .PREAMBLE  (PREAMBLE),
  .OVR_COUNT (OVR_COUNT)
) u_pbd_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .valid      (result_valid),
  .result     (result),
  .over_range (over_range),
  .burst_end  (burst_end),
  .count      (burst_count)
);

// File: tb/test_pulse_burst_decoder.sv
`timescale 1ns/1ps
module test_pulse_burst_decoder;

  localparam int CNT_W = 8;
  localparam int GAP_W = 6;
  localparam int PRE   = 20;
  localparam int OVR   = 50;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             pulse_in;
  logic [GAP_W-1:0] idle_limit;
  logic [CNT_W-1:0] result;
  logic             result_valid;
  logic             over_range;

  int checks;
  int errors;
  int cyc;
  int vcount;
  int last_vcyc;
  int last_rise;
  logic [CNT_W-1:0] last_res;
  logic             last_ovr;
  bit done;

  pulse_burst_decoder #(
    .CNT_W     (CNT_W),
    .GAP_W     (GAP_W),
    .PREAMBLE  (PRE),
    .OVR_COUNT (OVR)
  ) i_pulse_burst_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .pulse_in     (pulse_in),
    .idle_limit   (idle_limit),
    .result       (result),
    .result_valid (result_valid),
    .over_range   (over_range)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (result_valid) begin
      vcount    <= vcount + 1;
      last_vcyc <= cyc;
      last_res  <= result;
      last_ovr  <= over_range;
    end
  end

  function automatic int exp_result(int n);
    int s;
    s = (n > MAXC) ? MAXC : n;
    return (s > PRE) ? s - PRE : 0;
  endfunction

  function automatic bit exp_ovr(int n);
    int s;
    s = (n > MAXC) ? MAXC : n;
    return s >= OVR;
  endfunction

  function automatic int eff_limit();
    return (idle_limit == '0) ? 1 : int'(idle_limit);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_pulses(int n, int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulse_in  = 1'b1;
      last_rise = cyc;
      wait_neg(1);
      @(negedge clk);
      pulse_in  = 1'b0;
      wait_neg(lo - 1);
    end
  endtask

  // One burst of n pulses, then full decode check.
  task automatic burst_check(int n, int lo);
    int v0;
    v0 = vcount;
    send_pulses(n, lo);
    wait_neg(eff_limit() + 10);
    if (n == 0) begin
      check("R8 no strobe on idle line", vcount - v0, 0);
    end else begin
      check("R6 one strobe per burst", vcount - v0, 1);
      check("R2/R3 result value", int'(last_res), exp_result(n));
      check("R4 over_range flag", int'(last_ovr), int'(exp_ovr(n)));
      check("R6 strobe latency", last_vcyc, last_rise + eff_limit() + 3);
    end
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    cyc       = 0;
    vcount    = 0;
    last_vcyc = 0;
    last_rise = 0;
    done      = 1'b0;
    pulse_in  = 1'b0;
    idle_limit = GAP_W'(8);
    rst_n     = 1'b0;
    void'($urandom(32'd4242));
    wait_neg(5);
    // R1: reset state
    check("R1 valid in reset", int'(result_valid), 0);
    check("R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    wait_neg(4);
    check("R1 valid after release", int'(result_valid), 0);
    check("R1 result after release", int'(result), 0);
    check("R1 over_range after release", int'(over_range), 0);

    // R8: idle line
    begin
      int v0;
      v0 = vcount;
      wait_neg(100);
      check("R8 idle line silent", vcount - v0, 0);
    end

    // Directed boundaries: R3, R2, R4
    burst_check(PRE, 2);
    burst_check(PRE + 1, 2);
    burst_check(1, 3);
    burst_check(OVR - 1, 3);
    burst_check(OVR, 2);
    // R9: saturation
    burst_check(MAXC + 15, 2);

    // R5: gap one below the split point keeps a single burst
    idle_limit = GAP_W'(6);
    burst_check(30, 4);
    // R5: gap at the split point separates every pulse
    begin
      int v0;
      v0 = vcount;
      send_pulses(3, 5);
      wait_neg(20);
      check("R5 split into separate bursts", vcount - v0, 3);
      check("R5 split burst result", int'(last_res), 0);
    end

    // R5: zero limit acts as one
    idle_limit = '0;
    begin
      int v0;
      v0 = vcount;
      send_pulses(3, 3);
      wait_neg(10);
      check("R5 zero limit strobes", vcount - v0, 3);
      check("R6 zero limit latency", last_vcyc, last_rise + 4);
    end

    // R7: outputs hold between strobes
    idle_limit = GAP_W'(8);
    burst_check(PRE + 7, 2);
    wait_neg(40);
    check("R7 result holds", int'(result), PRE + 7 - PRE);
    check("R7 over_range holds", int'(over_range), 0);

    // Constrained random bursts
    for (int k = 0; k < 14; k++) begin
      int n;
      int lo;
      idle_limit = GAP_W'($urandom_range(6, 12));
      n  = $urandom_range(0, 70);
      lo = $urandom_range(2, eff_limit() - 2);
      burst_check(n, lo);
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_neg(150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule